// File: doc/BRIEF.md
# JTAG scan path sequencer

This block is a test-access-port master. It drives TCK, TMS, TDI and an active-low TRST toward a target's TAP controller and samples TDO, so that a whole scan operation runs from a single command. Four operations are available: a hard reset through TRST, a walk to Run-Test/Idle through Test-Logic-Reset, an instruction scan, and an instruction scan followed at once by a data scan. Every scan begins and ends in Run-Test/Idle.

A command carries an opcode, instruction and data lengths, parallel shift-in values, a TCK half-period divider and a TRST hold length. All of these are latched when the command is accepted. While an operation runs, `busy` is high and further commands are ignored. A one-cycle `done` pulse marks the end, and at that point the bits shifted out of the target are valid on `ir_out` and `dr_out`, packed least significant bit first. In the combined operation the path runs from Update-IR directly to Select-DR-Scan and does not visit Run-Test/Idle in between.

Top module: `jtag_scan_master`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `tck` and `tdi` are 0, and `tms` and `trst_n` are 1.
- R2: Opcodes are 0 for hard reset, 1 for go-to-idle, 2 for instruction scan and 3 for instruction scan then data scan. `cmd_valid` is acted on only while `busy` is 0. A command seen while busy changes no output.
- R3: TCK runs only while an operation is busy. Each TCK cycle is high for `half_div`+1 clocks and then low for `half_div`+1 clocks. TMS and TDI take their new values in the clock where TCK rises and hold them through the fall. TCK is high in the first clock after the command is accepted.
- R4: For a hard reset, `trst_n` is low for exactly `trst_len`+1 clocks starting the clock after acceptance, with TCK held low. Then `trst_n` returns high and `done` pulses.
- R5: Go-to-idle produces five TCK cycles with TMS 1, which puts the TAP in Test-Logic-Reset, and then one cycle with TMS 0. TDI is 0 throughout.
- R6: An instruction scan of length n produces the TMS sequence 1,1,0,0, then n-1 zeros, then 1 (the last shift bit), then 1, then 0.
- R7: In the combined operation, the instruction part's Update-IR step is followed by TMS 1 (to Select-DR-Scan), then 0, 0, then m-1 zeros, then 1, 1 and 0, where m is the data length.
- R8: During the n shift cycles, TDI carries the input value least significant bit first, with bit k in shift cycle k. TDI is 0 in every other cycle.
- R9: TDO is sampled at the end of each low half. The sample from the cycle that enters Shift becomes output bit 0, and the sample from shift cycle k becomes bit k+1 for k < n-1. Output bits at or above the length stay 0, and both outputs are cleared when a scan is accepted.
- R10: `done` is a one-clock pulse in the clock where `busy` falls. TCK is low and the outputs are final in that clock.
- R11: A scan command with a zero length, or a length above the synthesis maximum (the data length is checked only for opcode 3), pulses `done` and `err` together in the next clock. It produces no TCK edge and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (R2) |
| ir_len | input | IRLW | Instruction shift length |
| dr_len | input | DRLW | Data shift length |
| ir_in | input | MAX_IR | Instruction bits to shift in |
| dr_in | input | MAX_DR | Data bits to shift in |
| half_div | input | DIV_W | TCK half-period minus one, in clocks |
| trst_len | input | TRST_W | TRST low time minus one, in clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| err | output | 1 | Rejected command pulse |
| ir_out | output | MAX_IR | Instruction bits shifted out |
| dr_out | output | MAX_DR | Data bits shifted out |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward target |
| trst_n | output | 1 | Test reset, active low |
| tdo | input | 1 | Test data from target |

## Verification
The hardest case to reach from the ports is the turn from Update-IR into Select-DR-Scan. A wrong TMS value at that point leaves the target in the wrong register, yet nothing on the master's own outputs shows it. The bench therefore runs a behavioural TAP controller that follows TCK and TMS. That model checks the latched instruction and data values and the final state, and it drives TDO with known capture patterns so that the packing of the output bits can be checked. To reach the edges of the shift path, combined scans are run at length 1 (where the Shift entry is immediately followed by Exit1) and at the maximum lengths. A hard-reset command is also injected in the middle of a scan to confirm that it is ignored.

// File: rtl/jtag_seq_pkg.sv
// Shared types for the JTAG scan path sequencer.
package jtag_seq_pkg;
    typedef enum logic [1:0] {
        OP_TRST = 2'd0,
        OP_RTI  = 2'd1,
        OP_IR   = 2'd2,
        OP_IRDR = 2'd3
    } op_e;

    // Each value names the TCK step currently being clocked out.
    typedef enum logic [3:0] {
        ST_IDLE, ST_TRST, ST_TLR, ST_FIN, ST_SELDR,
        ST_SELIR, ST_CAP, ST_ENSH, ST_SHIFT, ST_UPD
    } step_e;

    localparam int TLR_STEPS = 5;
endpackage

// File: rtl/jtag_half_timer.sv
// Half-period timer: counts system clocks while TCK is active and flags the
// last clock of each TCK half. Assumes div stays constant while run is high.
module jtag_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_end
);
    logic [DIV_W-1:0] cnt;

    assign half_end = run && (cnt == div);

    // Count up within a half and restart at its end or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || half_end) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> cnt <= div); // R3
endmodule

// File: rtl/jtag_scan_lane.sv
// Capture lane: assembles shifted-out TDO bits at indexed positions.
// Assumes clr and wr never coincide and idx < W whenever wr is high.
module jtag_scan_lane #(
    parameter int W  = 16,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic [W-1:0]  q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Clear on a new scan, load this bit when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                 q[i] <= 1'b0;
            else if (wr && (idx == IW'(i)))    q[i] <= bit_in;
        end
    end

    AST_LANE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (idx < IW'(W)) && !clr); // R9
endmodule

// File: rtl/jtag_path_ctrl.sv
// Path controller: accepts commands, walks the TAP state path one TCK step
// at a time, drives TMS/TDI/TRST and requests TDO captures. Assumes the
// half-period timer pulses half_end at the end of each TCK half.
module jtag_path_ctrl
    import jtag_seq_pkg::*;
#(
    parameter int MAX_IR = 16,
    parameter int MAX_DR = 32,
    parameter int DIV_W  = 8,
    parameter int TRST_W = 8,
    localparam int IRLW  = $clog2(MAX_IR + 1),
    localparam int DRLW  = $clog2(MAX_DR + 1),
    localparam int LW0   = (IRLW > DRLW) ? IRLW : DRLW,
    localparam int CW    = (LW0 > 3) ? LW0 : 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IRLW-1:0]   ir_len,
    input  logic [DRLW-1:0]   dr_len,
    input  logic [MAX_IR-1:0] ir_in,
    input  logic [MAX_DR-1:0] dr_in,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [TRST_W-1:0] trst_len,
    input  logic              tdo,
    input  logic              half_end,
    output logic              run,
    output logic [DIV_W-1:0]  div_cur,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              trst_n,
    output logic              cap_clr,
    output logic              cap_wr_ir,
    output logic              cap_wr_dr,
    output logic [CW-1:0]     cap_idx,
    output logic              cap_bit
);
    step_e              st, nst;
    logic [CW-1:0]      bc, nbc, irl_q, drl_q, cur_len, nlen;
    logic               scan_dr, ndr, with_dr, ph;
    logic [TRST_W-1:0]  rcnt, trl_q;
    logic [MAX_IR-1:0]  ir_q, ir_sh;
    logic [MAX_DR-1:0]  dr_q, dr_sh;
    logic               last_bit, n_tms, n_tdi, bad, sample, step_end;

    assign busy     = (st != ST_IDLE);
    assign run      = (st != ST_IDLE) && (st != ST_TRST);
    assign cur_len  = scan_dr ? drl_q : irl_q;
    assign last_bit = (bc == cur_len - 1'b1);
    assign step_end = half_end && ph;

    // Length check for scan commands.
    assign bad = (ir_len == '0) || (ir_len > IRLW'(MAX_IR)) ||
                 ((cmd_op == OP_IRDR) && ((dr_len == '0) || (dr_len > DRLW'(MAX_DR))));

    // Capture requests toward the lanes.
    assign sample    = (st == ST_ENSH) || ((st == ST_SHIFT) && !last_bit);
    assign cap_wr_ir = step_end && sample && !scan_dr;
    assign cap_wr_dr = step_end && sample && scan_dr;
    assign cap_idx   = (st == ST_ENSH) ? '0 : bc + 1'b1;
    assign cap_bit   = tdo;
    assign cap_clr   = (st == ST_IDLE) && cmd_valid && cmd_op[1] && !bad;

    // Next TAP step and its bit index after the current step completes.
    always_comb begin
        nst = st;
        nbc = bc;
        ndr = scan_dr;
        case (st)
            ST_TLR:   if (bc == CW'(TLR_STEPS - 1)) begin nst = ST_FIN; nbc = '0; end
                      else nbc = bc + 1'b1;
            ST_FIN:   nst = ST_IDLE;
            ST_SELDR: nst = scan_dr ? ST_CAP : ST_SELIR;
            ST_SELIR: nst = ST_CAP;
            ST_CAP:   nst = ST_ENSH;
            ST_ENSH:  begin nst = ST_SHIFT; nbc = '0; end
            ST_SHIFT: if (last_bit) nst = ST_UPD;
                      else nbc = bc + 1'b1;
            ST_UPD:   if (!scan_dr && with_dr) begin nst = ST_SELDR; ndr = 1'b1; end
                      else nst = ST_FIN;
            default:  ;
        endcase
    end

    // TMS and TDI levels that belong to the next step.
    always_comb begin
        nlen  = ndr ? drl_q : irl_q;
        ir_sh = ir_q >> nbc;
        dr_sh = dr_q >> nbc;
        case (nst)
            ST_TLR, ST_SELDR, ST_SELIR, ST_UPD: n_tms = 1'b1;
            ST_SHIFT: n_tms = (nbc == nlen - 1'b1);
            default:  n_tms = 1'b0;
        endcase
        n_tdi = (nst == ST_SHIFT) ? (ndr ? dr_sh[0] : ir_sh[0]) : 1'b0;
    end

    // Command acceptance, TRST timing and TCK step sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; bc <= '0; scan_dr <= 1'b0; with_dr <= 1'b0; ph <= 1'b0;
            rcnt <= '0; trl_q <= '0; ir_q <= '0; dr_q <= '0; irl_q <= '0; drl_q <= '0;
            div_cur <= '0; done <= 1'b0; err <= 1'b0;
            tck <= 1'b0; tms <= 1'b1; tdi <= 1'b0; trst_n <= 1'b1;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                ST_IDLE: if (cmd_valid) begin
                    irl_q <= CW'(ir_len); drl_q <= CW'(dr_len);
                    ir_q <= ir_in; dr_q <= dr_in; div_cur <= half_div; trl_q <= trst_len;
                    case (op_e'(cmd_op))
                        OP_TRST: begin st <= ST_TRST; trst_n <= 1'b0; rcnt <= '0; end
                        OP_RTI: begin
                            st <= ST_TLR; bc <= '0; ph <= 1'b0;
                            tck <= 1'b1; tms <= 1'b1; tdi <= 1'b0;
                        end
                        default: if (bad) begin
                            err <= 1'b1; done <= 1'b1;
                        end else begin
                            st <= ST_SELDR; bc <= '0; ph <= 1'b0; scan_dr <= 1'b0;
                            with_dr <= (cmd_op == OP_IRDR);
                            tck <= 1'b1; tms <= 1'b1; tdi <= 1'b0;
                        end
                    endcase
                end
                ST_TRST: if (rcnt == trl_q) begin
                    trst_n <= 1'b1; st <= ST_IDLE; done <= 1'b1;
                end else rcnt <= rcnt + 1'b1;
                default: if (half_end) begin
                    if (!ph) begin
                        tck <= 1'b0; ph <= 1'b1;
                    end else if (nst == ST_IDLE) begin
                        st <= ST_IDLE; done <= 1'b1;
                    end else begin
                        st <= nst; bc <= nbc; scan_dr <= ndr; ph <= 1'b0;
                        tck <= 1'b1; tms <= n_tms; tdi <= n_tdi;
                    end
                end
            endcase
        end
    end

    AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck); // R3
    AST_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tck) |-> $stable(tms) && $stable(tdi)); // R3
    AST_TRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trst_n |-> busy && !tck); // R4
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done && !tck); // R10
    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !busy && !tck); // R11
endmodule

// File: rtl/jtag_scan_master.sv
// JTAG scan master top: ties the path controller, the TCK half-period timer
// and the two capture lanes together. Assumes tdo is synchronous to clk.
module jtag_scan_master #(
    parameter int MAX_IR = 16,
    parameter int MAX_DR = 32,
    parameter int DIV_W  = 8,
    parameter int TRST_W = 8,
    localparam int IRLW  = $clog2(MAX_IR + 1),
    localparam int DRLW  = $clog2(MAX_DR + 1),
    localparam int LW0   = (IRLW > DRLW) ? IRLW : DRLW,
    localparam int CW    = (LW0 > 3) ? LW0 : 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IRLW-1:0]   ir_len,
    input  logic [DRLW-1:0]   dr_len,
    input  logic [MAX_IR-1:0] ir_in,
    input  logic [MAX_DR-1:0] dr_in,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [TRST_W-1:0] trst_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [MAX_IR-1:0] ir_out,
    output logic [MAX_DR-1:0] dr_out,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              trst_n,
    input  logic              tdo
);
    logic             run, half_end, cap_clr, cap_wr_ir, cap_wr_dr, cap_bit;
    logic [DIV_W-1:0] div_cur;
    logic [CW-1:0]    cap_idx;

    jtag_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_cur), .half_end(half_end));

    jtag_path_ctrl #(.MAX_IR(MAX_IR), .MAX_DR(MAX_DR), .DIV_W(DIV_W), .TRST_W(TRST_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .ir_len(ir_len), .dr_len(dr_len), .ir_in(ir_in), .dr_in(dr_in),
        .half_div(half_div), .trst_len(trst_len), .tdo(tdo), .half_end(half_end),
        .run(run), .div_cur(div_cur), .busy(busy), .done(done), .err(err),
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
        .cap_clr(cap_clr), .cap_wr_ir(cap_wr_ir), .cap_wr_dr(cap_wr_dr),
        .cap_idx(cap_idx), .cap_bit(cap_bit));

    jtag_scan_lane #(.W(MAX_IR), .IW(CW)) u_ir_lane (
        .clk(clk), .rst_n(rst_n), .clr(cap_clr), .wr(cap_wr_ir),
        .idx(cap_idx), .bit_in(cap_bit), .q(ir_out));

    jtag_scan_lane #(.W(MAX_DR), .IW(CW)) u_dr_lane (
        .clk(clk), .rst_n(rst_n), .clr(cap_clr), .wr(cap_wr_dr),
        .idx(cap_idx), .bit_in(cap_bit), .q(dr_out));
endmodule

// File: tb/jtag_scan_master_test.sv
module jtag_scan_master_test;
    localparam int MAX_IR = 16, MAX_DR = 32, DIV_W = 8, TRST_W = 8;
    localparam int IRLW = $clog2(MAX_IR + 1), DRLW = $clog2(MAX_DR + 1);
    localparam logic [63:0] CAPIR = 64'h0000_0000_0000_A5C3;
    localparam logic [63:0] CAPDR = 64'h0000_0000_3C96_D12B;
    localparam logic [63:0] IRRST = 64'h1;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, tdo = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [IRLW-1:0] ir_len = '0;
    logic [DRLW-1:0] dr_len = '0;
    logic [MAX_IR-1:0] ir_in = '0;
    logic [MAX_DR-1:0] dr_in = '0;
    logic [DIV_W-1:0] half_div = '0;
    logic [TRST_W-1:0] trst_len = '0;
    logic busy, done, err, tck, tms, tdi, trst_n;
    logic [MAX_IR-1:0] ir_out;
    logic [MAX_DR-1:0] dr_out;

    int vectors = 0, miscompares = 0;

    always #4 clk = ~clk;

    jtag_scan_master #(.MAX_IR(MAX_IR), .MAX_DR(MAX_DR), .DIV_W(DIV_W), .TRST_W(TRST_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .ir_len(ir_len), .dr_len(dr_len), .ir_in(ir_in), .dr_in(dr_in),
        .half_div(half_div), .trst_len(trst_len), .busy(busy), .done(done), .err(err),
        .ir_out(ir_out), .dr_out(dr_out), .tck(tck), .tms(tms), .tdi(tdi),
        .trst_n(trst_n), .tdo(tdo));

    // Behavioural target TAP: steps on each observed TCK fall.
    int tap = 0, t_irl = 1, t_drl = 1;
    logic [63:0] ir_sr = '0, dr_sr = '0, ir_upd = IRRST, dr_upd = '0;
    logic prev_tck = 1'b0;

    function automatic int tap_next(int s, logic m);
        case (s)
            0: return m ? 0 : 1;   1: return m ? 2 : 1;
            2: return m ? 9 : 3;   3: return m ? 5 : 4;
            4: return m ? 5 : 4;   5: return m ? 8 : 6;
            6: return m ? 7 : 6;   7: return m ? 8 : 4;
            8: return m ? 2 : 1;   9: return m ? 0 : 10;
            10: return m ? 12 : 11; 11: return m ? 12 : 11;
            12: return m ? 15 : 13; 13: return m ? 14 : 13;
            14: return m ? 15 : 11; default: return m ? 2 : 1;
        endcase
    endfunction

    function automatic logic [63:0] mask(int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    always @(negedge clk) begin
        if (!trst_n) begin
            tap = 0; ir_upd = IRRST;
        end else if (prev_tck && !tck) begin
            if (tap == 10) ir_sr = CAPIR & mask(t_irl);
            if (tap == 3)  dr_sr = CAPDR & mask(t_drl);
            if (tap == 11) ir_sr = (ir_sr >> 1) | (64'(tdi) << (t_irl - 1));
            if (tap == 4)  dr_sr = (dr_sr >> 1) | (64'(tdi) << (t_drl - 1));
            if (tap == 15) ir_upd = ir_sr;
            if (tap == 8)  dr_upd = dr_sr;
            tap = tap_next(tap, tms);
            if (tap == 0) ir_upd = IRRST;
        end
        tdo = (tap == 11) ? ir_sr[0] : (tap == 4) ? dr_sr[0] : 1'b0;
        prev_tck = tck;
    end

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected step list for the reference model.
    bit qtms[$];
    bit qtdi[$];

    task automatic build(input int op, input int n, input int m, input logic [63:0] iv, input logic [63:0] dv);
        qtms.delete(); qtdi.delete();
        if (op == 1) begin
            for (int i = 0; i < 5; i++) begin qtms.push_back(1); qtdi.push_back(0); end
            qtms.push_back(0); qtdi.push_back(0);
            return;
        end
        qtms.push_back(1); qtdi.push_back(0);
        qtms.push_back(1); qtdi.push_back(0);
        qtms.push_back(0); qtdi.push_back(0);
        qtms.push_back(0); qtdi.push_back(0);
        for (int k = 0; k < n; k++) begin qtms.push_back(k == n - 1); qtdi.push_back(iv[k]); end
        qtms.push_back(1); qtdi.push_back(0);
        if (op == 3) begin
            qtms.push_back(1); qtdi.push_back(0);
            qtms.push_back(0); qtdi.push_back(0);
            qtms.push_back(0); qtdi.push_back(0);
            for (int k = 0; k < m; k++) begin qtms.push_back(k == m - 1); qtdi.push_back(dv[k]); end
            qtms.push_back(1); qtdi.push_back(0);
        end
        qtms.push_back(0); qtdi.push_back(0);
    endtask

    // Issue a TCK operation and compare every clock against the model.
    task automatic run_op(input int op, input int n, input int m, input logic [63:0] iv,
                          input logic [63:0] dv, input int h, input int inj);
        int cyc = 0;
        string rq = (op == 1) ? "R5" : (op == 2) ? "R6" : "R7";
        t_irl = n; t_drl = m;
        build(op, n, m, iv, dv);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); ir_len = IRLW'(n); dr_len = DRLW'(m);
        ir_in = MAX_IR'(iv); dr_in = MAX_DR'(dv); half_div = DIV_W'(h - 1);
        @(negedge clk);
        cmd_valid = 0;
        for (int s = 0; s < qtms.size(); s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < h; c++) begin
                    cmp("R3", "tck", 64'(tck), 64'(p == 0));
                    cmp(rq, "tms", 64'(tms), 64'(qtms[s]));
                    cmp("R8", "tdi", 64'(tdi), 64'(qtdi[s]));
                    cmp("R2", "busy", 64'(busy), 64'd1);
                    cmp("R10", "done", 64'(done), 64'd0);
                    cmp("R2", "trst_n", 64'(trst_n), 64'd1);
                    if (cyc == inj) begin cmd_valid = 1; cmd_op = 2'd0; end
                    else if (cyc == inj + 1) cmd_valid = 0;
                    cyc++;
                    @(negedge clk);
                end
            end
        end
        cmd_valid = 0;
        cmp("R10", "done", 64'(done), 64'd1);
        cmp("R10", "busy", 64'(busy), 64'd0);
        cmp("R10", "tck", 64'(tck), 64'd0);
        cmp("R11", "err", 64'(err), 64'd0);
        cmp(rq, "tap state", 64'(tap), 64'd1);
        if (op >= 2) begin
            cmp("R9", "ir_out", 64'(ir_out), CAPIR & mask(n));
            cmp("R8", "ir latched", ir_upd, iv & mask(n));
        end
        if (op == 3) begin
            cmp("R9", "dr_out", 64'(dr_out), CAPDR & mask(m));
            cmp("R8", "dr latched", dr_upd, dv & mask(m));
        end
        if (op == 2) cmp("R9", "dr_out cleared", 64'(dr_out), 64'd0);
        @(negedge clk);
        cmp("R10", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic run_trst(input int nlen);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd0; trst_len = TRST_W'(nlen);
        @(negedge clk);
        cmd_valid = 0;
        for (int c = 0; c <= nlen; c++) begin
            cmp("R4", "trst_n low", 64'(trst_n), 64'd0);
            cmp("R4", "tck", 64'(tck), 64'd0);
            cmp("R4", "busy", 64'(busy), 64'd1);
            @(negedge clk);
        end
        cmp("R4", "trst_n released", 64'(trst_n), 64'd1);
        cmp("R10", "done", 64'(done), 64'd1);
        cmp("R4", "tap state", 64'(tap), 64'd0);
    endtask

    task automatic run_bad(input int op, input int n, input int m);
        int tap0 = tap;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); ir_len = IRLW'(n); dr_len = DRLW'(m);
        @(negedge clk);
        cmd_valid = 0;
        cmp("R11", "err", 64'(err), 64'd1);
        cmp("R11", "done", 64'(done), 64'd1);
        cmp("R11", "busy", 64'(busy), 64'd0);
        for (int c = 0; c < 3; c++) begin
            cmp("R11", "tck quiet", 64'(tck), 64'd0);
            @(negedge clk);
        end
        cmp("R11", "busy stays low", 64'(busy), 64'd0);
        cmp("R11", "tap unchanged", 64'(tap), 64'(tap0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp("R1", "busy", 64'(busy), 64'd0);
        cmp("R1", "done", 64'(done), 64'd0);
        cmp("R1", "err", 64'(err), 64'd0);
        cmp("R1", "tck", 64'(tck), 64'd0);
        cmp("R1", "tms", 64'(tms), 64'd1);
        cmp("R1", "tdi", 64'(tdi), 64'd0);
        cmp("R1", "trst_n", 64'(trst_n), 64'd1);
        run_op(1, 1, 1, 0, 0, 1, -1);                          // R5 from reset
        run_op(2, 5, 1, 64'h15, 0, 2, -1);                     // R6
        run_op(1, 1, 1, 0, 0, 1, -1);                          // R5 through reset state
        cmp("R5", "ir reset by TLR", ir_upd, IRRST);
        run_op(3, 4, 8, 64'h9, 64'hC5, 3, -1);                 // R7
        run_op(3, 1, 1, 64'h1, 64'h1, 1, -1);                  // R7 single-bit scans
        run_op(3, MAX_IR, MAX_DR, 64'hBEEF, 64'h8765_4321, 1, -1); // R7 maximum lengths
        run_op(2, 7, 1, 64'h4B, 0, 1, 5);                      // R2 ignored command while busy
        run_bad(2, 0, 1);                                      // R11 zero IR length
        run_bad(3, 3, 0);                                      // R11 zero DR length
        run_bad(3, MAX_IR + 1, 2);                             // R11 oversize
        run_trst(3);                                           // R4
        run_trst(0);                                           // R4 minimum hold
        run_op(1, 1, 1, 0, 0, 2, -1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule